// File: doc/BRIEF.md
# Byte-Segmented Wide-Word ALU

This block is an arithmetic and logic unit for two 22-bit operands. A processor reaches it only through an 8-bit bus. The processor fills each operand with three byte writes. Each write is steered to operand A or operand B by a select code. The processor then writes a 6-bit operation code. The unit processes the word in three 8-bit slices, one slice per clock, starting at the low byte. The carry or borrow is kept in a register between slices. The 22-bit result is then read back one byte at a time, low byte first.

Every bus strobe, along with its select, direction and data, first passes through one register stage that ties it to the system clock. The strobe acts on the next rising edge after that. Status flags for carry, borrow, zero and illegal operation are updated when the last slice completes.

Top module: `wide_alu`

## Requirements
- R1: After reset, busy, carry_out, borrow, zero and illegal are 0, and bus_rdata reads 0.
- R2: A write strobe (bus_we=1) with bus_sel=1 loads operand A, and with bus_sel=2 loads operand B. Each operand has its own byte pointer. Three writes fill bits 7:0, then 15:8, then 21:16, and the pointer then wraps back to the low byte. Bits 7:6 of the third byte are discarded.
- R3: Every strobe is registered once before it acts. An operation strobe sampled at clock edge k raises busy at edge k+1, and not earlier.
- R4: A write with bus_sel=3 takes bus_wdata[5:0] as the operation code and starts a run. Busy then stays high for exactly three clock cycles, one for each slice.
- R5: The operation codes are: 0 gives A+B, 1 gives A-B, 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, 5 gives NOT A, and 6 gives B. All results are taken modulo 2^22.
- R6: Any operation code from 7 to 63 gives a result of 0 and sets illegal.
- R7: carry_out is set only after an add whose true sum exceeds 22 bits. Every other run clears it.
- R8: borrow is set only after a subtract with B greater than A. Every other run clears it.
- R9: zero is set after a run exactly when all 22 result bits are 0.
- R10: A strobe with bus_we=0 and bus_sel=4 advances the read pointer. bus_rdata shows result bits 7:0, then 15:8, then 21:16 with bits 7:6 at 0, and then wraps. The read pointer returns to the low byte when a run completes.
- R11: Operand writes and operation writes that act while busy is high are ignored.
- R12: Starting a run returns both operand byte pointers to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strb | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_sel | input | 3 | Select code: 1 operand A, 2 operand B, 3 operation, 4 result |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Result byte at the current read pointer |
| busy | output | 1 | High while the slices are being processed |
| carry_out | output | 1 | Carry out of bit 21 after an add |
| borrow | output | 1 | Borrow after a subtract |
| zero | output | 1 | The 22-bit result is zero |
| illegal | output | 1 | The last operation code was undefined |

## Verification
Adds are run with a carry that ripples through all three slices, with a carry that crosses only the first slice boundary, and with a carry that leaves bit 21. Comparing these shows whether the carry register links the slices and whether the top slice is correctly narrowed to 6 bits. Subtracts are run with B both below and above A, so the borrow that passes between slices and the final borrow flag are each checked. Every logic code is run on patterns whose slices differ, which catches slice misplacement. Two undefined codes, an oversized third byte, a write sent during a run, and a read sequence that wraps cover the ignore and wrap rules.

// File: rtl/wide_alu.sv
module wide_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_strb,
  input  logic       bus_we,
  input  logic [2:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       busy,
  output logic       carry_out,
  output logic       borrow,
  output logic       zero,
  output logic       illegal
);
  localparam logic [2:0] SEL_A = 3'd1, SEL_B = 3'd2, SEL_OP = 3'd3, SEL_RES = 3'd4;

  logic       s_strb, s_we;
  logic [2:0] s_sel;
  logic [7:0] s_data;
  logic [21:0] opa, opb, res, res_nx;
  logic [1:0] pa, pb, seg, rp;
  logic [5:0] op;
  logic       cy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_strb <= 1'b0; s_we <= 1'b0; s_sel <= '0; s_data <= '0;
    end else begin
      s_strb <= bus_strb; s_we <= bus_we; s_sel <= bus_sel; s_data <= bus_wdata;
    end

  wire ld_a  = s_strb &  s_we & (s_sel == SEL_A)   & ~busy;
  wire ld_b  = s_strb &  s_we & (s_sel == SEL_B)   & ~busy;
  wire go    = s_strb &  s_we & (s_sel == SEL_OP)  & ~busy;
  wire rd_nx = s_strb & ~s_we & (s_sel == SEL_RES) & ~busy;

  function automatic logic [7:0] slice_of(input logic [21:0] v, input logic [1:0] i);
    logic [23:0] w;
    w = {2'b00, v};
    return w[8*i +: 8];
  endfunction

  function automatic logic [21:0] put(input logic [21:0] v, input logic [1:0] i,
                                      input logic [7:0] b);
    case (i)
      2'd0:    return {v[21:8], b};
      2'd1:    return {v[21:16], b, v[7:0]};
      default: return {b[5:0], v[15:0]};
    endcase
  endfunction

  wire       last = (seg == 2'd2);
  wire [7:0] msk  = last ? 8'h3F : 8'hFF;
  wire [7:0] a_s  = slice_of(opa, seg);
  wire [7:0] b_s  = slice_of(opb, seg);
  wire [7:0] b_e  = ((op == 6'd1) ? ~b_s : b_s) & msk;
  wire [8:0] sum  = {1'b0, a_s} + {1'b0, b_e} + {8'd0, cy};
  wire       c_nx = last ? sum[6] : sum[8];
  logic [7:0] sl;

  always_comb begin
    case (op)
      6'd0, 6'd1: sl = sum[7:0];
      6'd2:       sl = a_s & b_s;
      6'd3:       sl = a_s | b_s;
      6'd4:       sl = a_s ^ b_s;
      6'd5:       sl = ~a_s;
      6'd6:       sl = b_s;
      default:    sl = 8'h00;
    endcase
    sl = sl & msk;
  end

  assign res_nx = put(res, seg, sl);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      opa <= '0; opb <= '0; pa <= '0; pb <= '0;
    end else if (go) begin
      pa <= '0; pb <= '0;
    end else begin
      if (ld_a) begin opa <= put(opa, pa, s_data); pa <= (pa == 2'd2) ? 2'd0 : pa + 2'd1; end
      if (ld_b) begin opb <= put(opb, pb, s_data); pb <= (pb == 2'd2) ? 2'd0 : pb + 2'd1; end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; seg <= '0; op <= '0; cy <= 1'b0; res <= '0; rp <= '0;
      carry_out <= 1'b0; borrow <= 1'b0; zero <= 1'b0; illegal <= 1'b0;
    end else if (go) begin
      busy <= 1'b1; seg <= '0; op <= s_data[5:0]; cy <= (s_data[5:0] == 6'd1);
      carry_out <= 1'b0; borrow <= 1'b0; zero <= 1'b0; illegal <= 1'b0;
    end else if (busy) begin
      res <= res_nx;
      cy  <= c_nx;
      seg <= seg + 2'd1;
      if (last) begin
        busy      <= 1'b0;
        rp        <= '0;
        carry_out <= (op == 6'd0) & c_nx;
        borrow    <= (op == 6'd1) & ~c_nx;
        zero      <= (res_nx == '0);
        illegal   <= (op > 6'd6);
      end
    end else if (rd_nx) begin
      rp <= (rp == 2'd2) ? 2'd0 : rp + 2'd1;
    end

  assign bus_rdata = slice_of(res, rp);
endmodule

// File: rtl/wide_alu_chk.sv
module wide_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        carry_out,
  input logic        borrow,
  input logic        zero,
  input logic        illegal,
  input logic [7:0]  bus_rdata,
  input logic [1:0]  rp,
  input logic [21:0] opa,
  input logic [21:0] opb,
  input logic [21:0] res
);
  p_busy_three_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(opa) && $stable(opb)));

  p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({carry_out, borrow, illegal}));

  p_top_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rp == 2'd2) |-> (bus_rdata[7:6] == 2'b00));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (zero == (res == 22'd0)));
endmodule

bind wide_alu wide_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .carry_out(carry_out),
  .borrow(borrow), .zero(zero), .illegal(illegal), .bus_rdata(bus_rdata),
  .rp(rp), .opa(opa), .opb(opb), .res(res)
);

// File: tb/wide_alu_tb.sv
module wide_alu_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_strb = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic busy, carry_out, borrow, zero, illegal;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wide_alu u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic we, logic [2:0] sel, logic [7:0] d);
    @(negedge clk); bus_strb = 1'b1; bus_we = we; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_strb = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(logic [2:0] sel, logic [21:0] v);
    pulse(1'b1, sel, v[7:0]);
    pulse(1'b1, sel, v[15:8]);
    pulse(1'b1, sel, {2'b00, v[21:16]});
  endtask

  task automatic run_op(string req, logic [5:0] code, logic [21:0] a, logic [21:0] b);
    logic [22:0] r;
    logic c, bw, il;
    c = 0; bw = 0; il = 0;
    case (code)
      0: begin r = {1'b0, a} + {1'b0, b}; c = r[22]; end
      1: begin r = {1'b0, a} - {1'b0, b}; bw = (b > a); end
      2: r = {1'b0, a & b};
      3: r = {1'b0, a | b};
      4: r = {1'b0, a ^ b};
      5: r = {1'b0, ~a};
      6: r = {1'b0, b};
      default: begin r = '0; il = 1; end
    endcase
    load(3'd1, a);
    load(3'd2, b);
    pulse(1'b1, 3'd3, {2'b00, code});
    for (int n = 0; n < 2; n++) begin
      chk({req, " R4 busy"}, busy, 1'b1);
      @(negedge clk);
    end
    chk({req, " R4 busy last"}, busy, 1'b1);
    @(negedge clk);
    chk({req, " R4 done"}, busy, 1'b0);
    chk({req, " R7 carry"}, carry_out, c);
    chk({req, " R8 borrow"}, borrow, bw);
    chk({req, " R6 illegal"}, illegal, il);
    chk({req, " R9 zero"}, zero, (r[21:0] == 0));
    for (int k = 0; k < 3; k++) begin
      logic [23:0] w;
      w = {2'b00, r[21:0]};
      chk({req, " R10 byte"}, bus_rdata, w[8*k +: 8]);
      pulse(1'b0, 3'd4, 8'h00);
    end
    chk({req, " R10 wrap"}, bus_rdata, r[7:0]);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 flags", {carry_out, borrow, zero, illegal}, 0);
    chk("R1 rdata", bus_rdata, 0);
  endtask

  task automatic t_sync;
    @(negedge clk); bus_strb = 1; bus_we = 1; bus_sel = 3'd3; bus_wdata = 8'd6;
    @(negedge clk); bus_strb = 0;
    chk("R3 not yet", busy, 0);
    @(negedge clk);
    chk("R3 busy up", busy, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_top_bits;
    pulse(1'b1, 3'd1, 8'h00); pulse(1'b1, 3'd1, 8'h00); pulse(1'b1, 3'd1, 8'hFF);
    pulse(1'b1, 3'd3, 8'd5);
    repeat (4) @(negedge clk);
    chk("R2 top bits dropped", bus_rdata, 8'hFF);
    pulse(1'b0, 3'd4, 0);
    chk("R2 mid", bus_rdata, 8'hFF);
    pulse(1'b0, 3'd4, 0);
    chk("R2 high", bus_rdata, 8'h00);
  endtask

  task automatic t_ignore;
    load(3'd1, 22'h012345);
    @(negedge clk); bus_strb = 1; bus_we = 1; bus_sel = 3'd3; bus_wdata = 8'd5;
    @(negedge clk); bus_sel = 3'd1; bus_wdata = 8'hAA;
    @(negedge clk); bus_strb = 0;
    repeat (4) @(negedge clk);
    chk("R11 busy done", busy, 0);
    chk("R11 A intact", bus_rdata, 8'hBA);
    @(negedge clk); bus_strb = 1; bus_sel = 3'd3; bus_wdata = 8'd5;
    @(negedge clk); bus_wdata = 8'd6;
    @(negedge clk); bus_strb = 0;
    repeat (4) @(negedge clk);
    chk("R11 op ignored", bus_rdata, 8'hBA);
  endtask

  task automatic t_ptr_reset;
    pulse(1'b1, 3'd2, 8'h11);
    pulse(1'b1, 3'd3, 8'd6);
    repeat (4) @(negedge clk);
    pulse(1'b1, 3'd2, 8'h77);
    pulse(1'b1, 3'd3, 8'd6);
    repeat (4) @(negedge clk);
    chk("R12 ptr low", bus_rdata, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sync();
    run_op("R5 add ripple",  6'd0, 22'h3FFFFF, 22'h000001);
    run_op("R5 add byte",    6'd0, 22'h0000FF, 22'h000001);
    run_op("R5 add plain",   6'd0, 22'h12F0A5, 22'h0A1B2C);
    run_op("R5 add carry",   6'd0, 22'h200000, 22'h200003);
    run_op("R5 sub borrow",  6'd1, 22'h000005, 22'h000007);
    run_op("R5 sub plain",   6'd1, 22'h100000, 22'h000001);
    run_op("R5 sub zero",    6'd1, 22'h2ABCDE, 22'h2ABCDE);
    run_op("R5 and",         6'd2, 22'h3C5A0F, 22'h0FF0F3);
    run_op("R5 or",          6'd3, 22'h010203, 22'h302010);
    run_op("R5 xor",         6'd4, 22'h3F00FF, 22'h0F0F0F);
    run_op("R5 not",         6'd5, 22'h0F00F0, 22'h000000);
    run_op("R5 pass",        6'd6, 22'h000001, 22'h2468AC);
    run_op("R6 code7",       6'd7, 22'h123456, 22'h111111);
    run_op("R6 code63",      6'd63, 22'h3FFFFF, 22'h3FFFFF);
    t_top_bits();
    t_ignore();
    t_ptr_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule